// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor model through three power states: Normal, Stop-Grant and Sleep. Two active-low requests drive it, stop-clock and sleep, plus the active-low asynchronous reset. Both requests may arrive with no relation to the clock. Each one passes through a two-flop synchronizer before the state machine uses it. The outputs are clock enables for three domains: core, bus unit and interrupt-controller unit. Alongside these it gives a one-cycle request to issue a Stop-Grant acknowledge, acceptance gates for snoops and interrupts, and a pending-interrupt flag.

Clock gating has two levels. Stop-Grant halts only the core; the bus and interrupt-controller clocks keep running, so snoops are still served and interrupts are latched as pending. Sleep can only be reached from Stop-Grant and turns off every enable. Only the PLL-alive indication stays high. When the block returns to Normal, a one-cycle service pulse releases any interrupt latched while execution was halted.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it goes high, the block is in Normal. In Normal every clock enable is 1, snoop_en_o and intr_en_o are 1, and intr_pend_o, sg_ack_o and intr_svc_o are 0.
- R2: stpclk_ni driven low in Normal is captured by the synchronizer and then the state register, so Stop-Grant is reached three rising edges after the change. In Stop-Grant core_clk_en_o is 0 while bus_clk_en_o and intc_clk_en_o stay 1.
- R3: sg_ack_o is 1 for exactly the first cycle of a Stop-Grant entered from Normal. It stays 0 when Stop-Grant is re-entered from Sleep.
- R4: In Stop-Grant, snoop_en_o and intr_en_o are 1. An intr_i pulse sets intr_pend_o. In Normal, intr_i never sets intr_pend_o.
- R5: slp_ni driven low in Normal has no effect: all outputs keep their Normal values.
- R6: slp_ni driven low in Stop-Grant enters Sleep three edges later. In Sleep all three clock enables, snoop_en_o and intr_en_o are 0, and pll_alive_o stays 1.
- R7: In Sleep, intr_i does not change intr_pend_o. Releasing stpclk_ni while slp_ni is still low keeps the block in Sleep.
- R8: slp_ni released in Sleep returns the block to Stop-Grant three edges later. Bus and interrupt-controller enables return to 1 and core stays off.
- R9: stpclk_ni released in Stop-Grant enters Normal three edges later. In that first Normal cycle intr_i svc pulse intr_svc_o equals the pending flag. intr_svc_o lasts one cycle, and intr_pend_o is 0 from then on.
- R10: If stop-clock was released during Sleep, releasing sleep gives exactly one Stop-Grant cycle and then Normal.
- R11: Driving rst_ni low in Sleep returns all outputs to the Normal values at once, with the pending flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stpclk_ni | input | 1 | Active-low stop-clock request, asynchronous |
| slp_ni | input | 1 | Active-low sleep request, asynchronous |
| intr_i | input | 1 | Interrupt request, sampled each cycle |
| core_clk_en_o | output | 1 | Core-unit clock enable |
| bus_clk_en_o | output | 1 | Bus-unit clock enable |
| intc_clk_en_o | output | 1 | Interrupt-controller clock enable |
| pll_alive_o | output | 1 | PLL running indication |
| snoop_en_o | output | 1 | Snoop acceptance gate |
| intr_en_o | output | 1 | Interrupt acceptance gate |
| intr_pend_o | output | 1 | Interrupt latched during Stop-Grant |
| sg_ack_o | output | 1 | One-cycle Stop-Grant acknowledge request |
| intr_svc_o | output | 1 | One-cycle pulse to service pending interrupts |

## Verification
A level change on stpclk_ni or slp_ni reaches the outputs on the third rising edge after it. The first two edges load the synchronizer and the third loads the state. The bench drives each change on a falling edge and samples once after two edges, where the old state must still show. It samples again after the third edge, where the new state must show. intr_i acts on the next rising edge. sg_ack_o and intr_svc_o are registered together with the state, so they are checked in the first cycle of the new state and again one cycle later, when they must have dropped.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_NORMAL    = 2'd0,
    PS_STOPGRANT = 2'd1,
    PS_SLEEP     = 2'd2
  } pwr_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stp_req_i,
  input  logic       slp_req_i,
  input  logic       intr_i,
  output pwr_state_e state_o,
  output logic       sg_ack_o,
  output logic       intr_pend_o,
  output logic       intr_svc_o
);
  pwr_state_e state_q, state_d;
  logic       sg_exit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_NORMAL:    if (stp_req_i) state_d = PS_STOPGRANT;
      PS_STOPGRANT: if (!stp_req_i) state_d = PS_NORMAL;
                    else if (slp_req_i) state_d = PS_SLEEP;
      PS_SLEEP:     if (!slp_req_i) state_d = PS_STOPGRANT;
      default:      state_d = PS_NORMAL;
    endcase
  end

  assign sg_exit = (state_q == PS_STOPGRANT) && !stp_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_NORMAL;
      sg_ack_o    <= 1'b0;
      intr_pend_o <= 1'b0;
      intr_svc_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      sg_ack_o   <= (state_q == PS_NORMAL) && stp_req_i;
      intr_svc_o <= sg_exit && (intr_pend_o || intr_i);
      if (sg_exit || state_q == PS_NORMAL) intr_pend_o <= 1'b0;
      else if (state_q == PS_STOPGRANT && intr_i) intr_pend_o <= 1'b1;
    end
  end

  assign state_o = state_q;

  assert_ack_from_normal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_ack_o |-> $past(state_q == PS_NORMAL) && state_q == PS_STOPGRANT);
  assert_ack_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_ack_o |=> !sg_ack_o);
  assert_sleep_no_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PS_SLEEP |=> state_q != PS_NORMAL);
  assert_sleep_no_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SLEEP && !intr_pend_o) |=> !intr_pend_o);
  assert_svc_on_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_svc_o |-> $past(state_q == PS_STOPGRANT) && state_q == PS_NORMAL && !intr_pend_o);
endmodule

// File: rtl/pwr_gate_dec.sv
module pwr_gate_dec
  import pwr_pkg::*;
(
  input  pwr_state_e state_i,
  output logic       core_en_o,
  output logic       bus_en_o,
  output logic       intc_en_o,
  output logic       snoop_en_o,
  output logic       intr_en_o
);
  logic awake;
  assign awake      = (state_i != PS_SLEEP);
  assign core_en_o  = (state_i == PS_NORMAL);
  assign bus_en_o   = awake;
  assign intc_en_o  = awake;
  assign snoop_en_o = awake;
  assign intr_en_o  = awake;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stpclk_ni,
  input  logic slp_ni,
  input  logic intr_i,
  output logic core_clk_en_o,
  output logic bus_clk_en_o,
  output logic intc_clk_en_o,
  output logic pll_alive_o,
  output logic snoop_en_o,
  output logic intr_en_o,
  output logic intr_pend_o,
  output logic sg_ack_o,
  output logic intr_svc_o
);
  logic [1:0] req_n_sync;
  pwr_state_e state;

  pwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni, .d_i({stpclk_ni, slp_ni}), .q_o(req_n_sync)
  );

  pwr_fsm u_fsm (
    .clk_i, .rst_ni,
    .stp_req_i  (!req_n_sync[1]),
    .slp_req_i  (!req_n_sync[0]),
    .intr_i,
    .state_o    (state),
    .sg_ack_o,
    .intr_pend_o,
    .intr_svc_o
  );

  pwr_gate_dec u_dec (
    .state_i   (state),
    .core_en_o (core_clk_en_o),
    .bus_en_o  (bus_clk_en_o),
    .intc_en_o (intc_clk_en_o),
    .snoop_en_o,
    .intr_en_o
  );

  assign pll_alive_o = 1'b1;

  assert_sg_bus_alive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_clk_en_o && sg_ack_o |-> bus_clk_en_o && intc_clk_en_o && snoop_en_o);
endmodule

// File: tb/sim_pwr_state_ctrl.sv
module sim_pwr_state_ctrl;
  logic clk = 0, rst_ni = 0, stpclk_ni = 1, slp_ni = 1, intr_i = 0;
  logic core_en, bus_en, intc_en, pll, snp, ien, pend, ack, svc;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk_i(clk), .rst_ni, .stpclk_ni, .slp_ni, .intr_i,
    .core_clk_en_o(core_en), .bus_clk_en_o(bus_en), .intc_clk_en_o(intc_en),
    .pll_alive_o(pll), .snoop_en_o(snp), .intr_en_o(ien),
    .intr_pend_o(pend), .sg_ack_o(ack), .intr_svc_o(svc)
  );

  // bits: pll core bus intc snoop intr_en pend ack svc
  function automatic logic [8:0] exp_v(int st, logic p, logic a, logic s);
    case (st)
      0: return {6'b111111, 1'b0, 1'b0, s};
      1: return {6'b101111, p, a, 1'b0};
      default: return {6'b100000, p, 2'b00};
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [8:0] e);
    logic [8:0] g;
    g = {pll, core_en, bus_en, intc_en, snp, ien, pend, ack, svc};
    n_chk++;
    if (g !== e) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, g, e, $time);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog got=hang exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", exp_v(0, 0, 0, 0));
    rst_ni = 1;
    step(1);
    chk("R1 after release", exp_v(0, 0, 0, 0));
    intr_i = 1; step(1); intr_i = 0;
    chk("R4 no latch in Normal", exp_v(0, 0, 0, 0));
    slp_ni = 0; step(5);
    chk("R5 sleep ignored in Normal", exp_v(0, 0, 0, 0));
    slp_ni = 1; step(3);

    for (int sc = 0; sc < 4; sc++) begin
      logic di, ds;
      di = sc[0]; ds = sc[1];
      stpclk_ni = 0; step(2);
      chk("R2 latency still Normal", exp_v(0, 0, 0, 0));
      step(1);
      chk("R2 R3 Stop-Grant with ack", exp_v(1, 0, 1, 0));
      step(1);
      chk("R3 ack one cycle", exp_v(1, 0, 0, 0));
      if (di) begin
        intr_i = 1; step(1); intr_i = 0;
        chk("R4 latched in Stop-Grant", exp_v(1, 1, 0, 0));
      end
      if (ds) begin
        slp_ni = 0; step(2);
        chk("R6 latency still Stop-Grant", exp_v(1, di, 0, 0));
        step(1);
        chk("R6 Sleep", exp_v(2, di, 0, 0));
        intr_i = 1; step(1); intr_i = 0;
        chk("R7 intr ignored in Sleep", exp_v(2, di, 0, 0));
        stpclk_ni = 1; step(4);
        chk("R7 stays in Sleep", exp_v(2, di, 0, 0));
        slp_ni = 1; step(3);
        chk("R8 R10 back to Stop-Grant no ack", exp_v(1, di, 0, 0));
        step(1);
        chk("R10 R9 Normal with svc", exp_v(0, 0, 0, di));
      end else begin
        stpclk_ni = 1; step(2);
        chk("R9 latency still Stop-Grant", exp_v(1, di, 0, 0));
        step(1);
        chk("R9 Normal with svc", exp_v(0, 0, 0, di));
      end
      step(1);
      chk("R9 svc one cycle", exp_v(0, 0, 0, 0));
    end

    // R8 re-entry to Stop-Grant from Sleep while stop-clock held
    stpclk_ni = 0; step(3);
    intr_i = 1; step(1); intr_i = 0;
    slp_ni = 0; step(3);
    chk("R6 Sleep again", exp_v(2, 1, 0, 0));
    slp_ni = 1; step(3);
    chk("R8 Stop-Grant from Sleep", exp_v(1, 1, 0, 0));
    step(3);
    chk("R8 R3 holds Stop-Grant no ack", exp_v(1, 1, 0, 0));
    slp_ni = 0; step(3);
    chk("R6 Sleep third time", exp_v(2, 1, 0, 0));

    // R11 reset from Sleep
    rst_ni = 0; stpclk_ni = 1; slp_ni = 1;
    #1;
    chk("R11 reset in Sleep", exp_v(0, 0, 0, 0));
    step(1);
    rst_ni = 1; step(4);
    chk("R11 R1 Normal after reset", exp_v(0, 0, 0, 0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule